// File: doc/BRIEF.md
# Multiplexed BCD Display Scanner

This block sits behind a four-digit counting converter and in front of a time-multiplexed seven-segment display. When the converter signals that a count is ready, the block captures the four BCD digits, the polarity and two range flags it derives from the count. One flag marks a reading too small to trust. The other marks a reading beyond the display range. The captured values hold until the next capture, so a scan never shows a half-updated reading.

A prescaler sets how long each digit stays lit. The one-hot digit strobe visits the digits in a fixed order that is not their numeric order. The nibble of the lit digit is driven out as BCD and as a seven-segment code. A one-cycle sign strobe marks each new measurement. The sign is shown only in the two DC measurement modes. When the captured reading is out of range, the segments go dark while the converter's zero phase is active, so the display blinks at the sample rate.

Top module: `bcd_scan_display`

## Requirements
- R1: The digit strobe visits digits in the order 1, 3, 2, 4 and then wraps. Strobe bit k lights digit k+1. Digit 4 is the most significant digit and is taken from count_bcd[15:12]. Digit 1 is taken from count_bcd[3:0].
- R2: Exactly one strobe bit is high in every cycle. Each digit stays strobed for DWELL clock cycles.
- R3: bcd_out equals the captured nibble of the digit that is currently strobed.
- R4: seg is active high, packed as {g,f,e,d,c,b,a}. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). Nibble values 10 to 15 give all segments off.
- R5: On a clock edge where load is high, the block captures count_bcd, neg_in and both range flags, and the new values appear in the next cycle. Without load, the captured values do not change, whatever count_bcd and neg_in do.
- R6: under_flag is 1 when the captured count, read as a decimal number, is 100 or less.
- R7: over_flag is 1 when the captured count is greater than 1999. While over_flag and zero_phase are both high, seg is all zero.
- R8: sign_strobe is high for exactly the one cycle that follows a load edge. sign_neg shows the captured polarity when mode is 00 (DC volts) or 01 (DC current). It is 0 when mode is 10 (resistance) or 11 (AC volts).
- R9: After reset, the strobe is 0001 and the captured count is zero. The range flags, sign_strobe and sign_neg are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture pulse from the converter |
| count_bcd | input | 16 | Four BCD digits, most significant digit in the top nibble |
| neg_in | input | 1 | Polarity of the finished count, 1 = negative |
| mode | input | 2 | Measurement mode: 00 DC volts, 01 DC current, 10 resistance, 11 AC volts |
| zero_phase | input | 1 | High while the converter is in its zero phase |
| dig_strobe | output | 4 | One-hot digit strobe |
| bcd_out | output | 4 | BCD nibble of the strobed digit |
| seg | output | 7 | Seven-segment code of the strobed digit |
| sign_strobe | output | 1 | One-cycle pulse after each capture |
| sign_neg | output | 1 | Negative sign segment drive |
| under_flag | output | 1 | Captured reading is underrange |
| over_flag | output | 1 | Captured reading is overrange |

## Verification
Counts of 0000, 0100 and 0101 sit on either side of the underrange limit, and 1999 and 2000 sit on either side of the overrange limit. Together these show whether each compare uses the right bound and the right direction. A count of 1234 makes all four digits different, so a wrong scan order or a swapped nibble shows up in bcd_out. Digits 9, 8, 7 and 6 and a count containing nibbles A and F exercise the segment table, including the all-off codes. While no load is given, changing count_bcd, neg_in and mode, and toggling zero_phase with both in-range and out-of-range readings captured, separates the capture hold, the sign blanking by mode and the blink gating.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

   typedef enum logic [1:0] {
      MODE_DCV = 2'b00,
      MODE_DCI = 2'b01,
      MODE_OHM = 2'b10,
      MODE_ACV = 2'b11
   } meas_mode_e;

   // scan slot -> digit index (0 = least significant digit)
   function automatic logic [1:0] slot_to_digit(input logic [1:0] slot);
      case (slot)
         2'd0:    return 2'd0;
         2'd1:    return 2'd2;
         2'd2:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

   // active-high segments {g,f,e,d,c,b,a}
   function automatic logic [6:0] nibble_to_seg(input logic [3:0] n);
      case (n)
         4'd0:    return 7'h3F;
         4'd1:    return 7'h06;
         4'd2:    return 7'h5B;
         4'd3:    return 7'h4F;
         4'd4:    return 7'h66;
         4'd5:    return 7'h6D;
         4'd6:    return 7'h7D;
         4'd7:    return 7'h07;
         4'd8:    return 7'h7F;
         4'd9:    return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

endpackage

// File: rtl/dscan_timer.sv
module dscan_timer #(
   parameter int DWELL = 1000,
   parameter int NDIG  = 4,
   localparam int PW   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] slot
);

   logic tick;

   generate
      if (DWELL == 1) begin : g_no_prescale
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int CW = $clog2(DWELL);
         logic [CW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (pre_q == CW'(DWELL - 1)) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = (pre_q == CW'(DWELL - 1));
      end
   endgenerate

   logic [PW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (tick) begin
         slot_q <= (slot_q == PW'(NDIG - 1)) ? '0 : slot_q + 1'b1;
      end
   end

   assign slot = slot_q;

endmodule

// File: rtl/dscan_capture.sv
module dscan_capture #(
   parameter int NDIG      = 4,
   parameter int UNDER_LIM = 100,
   parameter int OVER_LIM  = 1999,
   localparam int CNTW     = 4 * NDIG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [CNTW-1:0] count_bcd,
   input  logic            neg_in,
   output logic [CNTW-1:0] cnt_q,
   output logic            neg_q,
   output logic            under_q,
   output logic            over_q,
   output logic            strobe_q
);

   function automatic int decimal_of(input logic [CNTW-1:0] v);
      int acc;
      acc = 0;
      for (int i = NDIG - 1; i >= 0; i--) begin
         acc = acc * 10 + int'(v[4*i +: 4]);
      end
      return acc;
   endfunction

   int value_in;
   assign value_in = decimal_of(count_bcd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         neg_q    <= 1'b0;
         under_q  <= 1'b0;
         over_q   <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= load;
         if (load) begin
            cnt_q   <= count_bcd;
            neg_q   <= neg_in;
            under_q <= (value_in <= UNDER_LIM);
            over_q  <= (value_in > OVER_LIM);
         end
      end
   end

endmodule

// File: rtl/dscan_segdec.sv
module dscan_segdec (
   input  logic [3:0] nib,
   input  logic       blank,
   output logic [6:0] seg
);
   import dscan_pkg::*;

   assign seg = blank ? 7'h00 : nibble_to_seg(nib);

endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display #(
   parameter int DWELL     = 1000,
   parameter int NDIG      = 4,
   parameter int UNDER_LIM = 100,
   parameter int OVER_LIM  = 1999
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [15:0] count_bcd,
   input  logic        neg_in,
   input  logic [1:0]  mode,
   input  logic        zero_phase,
   output logic [3:0]  dig_strobe,
   output logic [3:0]  bcd_out,
   output logic [6:0]  seg,
   output logic        sign_strobe,
   output logic        sign_neg,
   output logic        under_flag,
   output logic        over_flag
);
   import dscan_pkg::*;

   localparam int CNTW = 4 * NDIG;
   localparam int PW   = (NDIG > 1) ? $clog2(NDIG) : 1;

   generate
      if (NDIG != 4) begin : g_bad_ndig
         $error("bcd_scan_display: scan order is defined for four digits only");
      end
      if (DWELL < 1) begin : g_bad_dwell
         $error("bcd_scan_display: DWELL must be at least 1");
      end
      if (UNDER_LIM >= OVER_LIM) begin : g_bad_limits
         $error("bcd_scan_display: UNDER_LIM must be below OVER_LIM");
      end
   endgenerate

   logic [PW-1:0]   slot;
   logic [CNTW-1:0] cnt_q;
   logic            neg_q;
   logic [1:0]      dsel;
   logic [3:0]      mux_term [NDIG];
   logic [3:0]      nib_sel;
   logic            sign_show;

   dscan_timer #(.DWELL(DWELL), .NDIG(NDIG)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   dscan_capture #(.NDIG(NDIG), .UNDER_LIM(UNDER_LIM), .OVER_LIM(OVER_LIM)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .count_bcd (count_bcd),
      .neg_in    (neg_in),
      .cnt_q     (cnt_q),
      .neg_q     (neg_q),
      .under_q   (under_flag),
      .over_q    (over_flag),
      .strobe_q  (sign_strobe)
   );

   assign dsel = slot_to_digit(slot);

   generate
      for (genvar k = 0; k < NDIG; k++) begin : g_digit
         assign dig_strobe[k] = (int'(dsel) == k);
         assign mux_term[k]   = dig_strobe[k] ? cnt_q[4*k +: 4] : 4'h0;
      end
   endgenerate

   always_comb begin
      nib_sel = 4'h0;
      for (int k = 0; k < NDIG; k++) begin
         nib_sel = nib_sel | mux_term[k];
      end
   end

   assign bcd_out = nib_sel;

   dscan_segdec u_segdec (
      .nib   (nib_sel),
      .blank (over_flag & zero_phase),
      .seg   (seg)
   );

   assign sign_show = (meas_mode_e'(mode) == MODE_DCV) || (meas_mode_e'(mode) == MODE_DCI);
   assign sign_neg  = neg_q & sign_show;

endmodule

// File: rtl/dscan_checker.sv
module dscan_checker #(
   parameter int DWELL = 1000,
   parameter int NDIG  = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       load,
   input logic [1:0] mode,
   input logic       zero_phase,
   input logic [3:0] dig_strobe,
   input logic [3:0] bcd_out,
   input logic [6:0] seg,
   input logic       sign_strobe,
   input logic       sign_neg,
   input logic       under_flag,
   input logic       over_flag
);

   int dwell_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dwell_cnt <= 0;
      end else begin
         dwell_cnt <= (dwell_cnt == DWELL - 1) ? 0 : dwell_cnt + 1;
      end
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_strobe) == 1);

   a_r2_dwell: assert property (@(posedge clk) disable iff (!rst_n)
      (dwell_cnt != DWELL - 1) |=> $stable(dig_strobe));

   a_r1_after_d1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dig_strobe) == 4'b0001 && dig_strobe != 4'b0001) |-> dig_strobe == 4'b0100);

   a_r1_after_d3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dig_strobe) == 4'b0100 && dig_strobe != 4'b0100) |-> dig_strobe == 4'b0010);

   a_r1_after_d2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dig_strobe) == 4'b0010 && dig_strobe != 4'b0010) |-> dig_strobe == 4'b1000);

   a_r1_after_d4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dig_strobe) == 4'b1000 && dig_strobe != 4'b1000) |-> dig_strobe == 4'b0001);

   a_r4_invalid_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (bcd_out > 4'd9) |-> seg == 7'h00);

   a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> ($stable(under_flag) && $stable(over_flag)));

   a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(under_flag && over_flag));

   a_r7_blink_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (over_flag && zero_phase) |-> seg == 7'h00);

   a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> sign_strobe);

   a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sign_strobe |-> $past(load));

   a_r8_sign_blank: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |-> !sign_neg);

endmodule

bind bcd_scan_display dscan_checker #(.DWELL(DWELL), .NDIG(NDIG)) u_dscan_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load        (load),
   .mode        (mode),
   .zero_phase  (zero_phase),
   .dig_strobe  (dig_strobe),
   .bcd_out     (bcd_out),
   .seg         (seg),
   .sign_strobe (sign_strobe),
   .sign_neg    (sign_neg),
   .under_flag  (under_flag),
   .over_flag   (over_flag)
);

// File: tb/bcd_scan_display_tb.sv
`timescale 1ns/1ps
module bcd_scan_display_tb;

   localparam int DW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [15:0] count_bcd = 16'h0;
   logic        neg_in = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        zero_phase = 1'b0;
   logic [3:0]  dig_strobe;
   logic [3:0]  bcd_out;
   logic [6:0]  seg;
   logic        sign_strobe;
   logic        sign_neg;
   logic        under_flag;
   logic        over_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bcd_scan_display #(.DWELL(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .load(load), .count_bcd(count_bcd),
      .neg_in(neg_in), .mode(mode), .zero_phase(zero_phase),
      .dig_strobe(dig_strobe), .bcd_out(bcd_out), .seg(seg),
      .sign_strobe(sign_strobe), .sign_neg(sign_neg),
      .under_flag(under_flag), .over_flag(over_flag)
   );

   // behavioural reference state
   int          m_cyc;
   logic [15:0] m_cnt;
   bit          m_neg, m_under, m_over, m_sstb;
   int          scan_seq[4] = '{0, 2, 1, 3};

   function automatic int dec_of(input logic [15:0] v);
      return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic int seg_ref(input int n);
      case (n)
         0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
         4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
         8: return 'h7F; 9: return 'h6F;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cyc = 0; m_cnt = 16'h0; m_neg = 0; m_under = 0; m_over = 0; m_sstb = 0;
      end else begin
         m_cyc++;
         m_sstb = load;
         if (load) begin
            m_cnt   = count_bcd;
            m_neg   = neg_in;
            m_under = dec_of(count_bcd) <= 100;
            m_over  = dec_of(count_bcd) > 1999;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int d, nib, es;
      d   = scan_seq[(m_cyc / DW) % 4];
      nib = int'((m_cnt >> (4 * d)) & 16'hF);
      es  = (m_over && zero_phase) ? 0 : seg_ref(nib);
      chk("R1 R2 strobe", int'(dig_strobe), 1 << d);
      chk("R3 R5 bcd_out", int'(bcd_out), nib);
      chk("R4 R7 seg", int'(seg), es);
      chk("R8 sign_strobe", int'(sign_strobe), int'(m_sstb));
      chk("R8 sign_neg", int'(sign_neg), int'(m_neg && !mode[1]));
      chk("R6 under_flag", int'(under_flag), int'(m_under));
      chk("R7 over_flag", int'(over_flag), int'(m_over));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   task automatic capture(input logic [15:0] v, input bit neg);
      count_bcd = v; neg_in = neg; load = 1'b1;
      step(1);
      load = 1'b0;
      step(4 * DW * 2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk("R9 strobe", int'(dig_strobe), 1);
      chk("R9 flags", int'({under_flag, over_flag, sign_strobe, sign_neg}), 0);
      chk("R9 seg", int'(seg), 'h3F);
      step(4 * DW * 2);
      capture(16'h1234, 1'b1);          // R1 R3: distinct digits
      capture(16'h0000, 1'b0);          // R6
      capture(16'h0100, 1'b0);          // R6 boundary
      capture(16'h0101, 1'b1);          // R6 just above
      capture(16'h1999, 1'b0);          // R7 boundary
      capture(16'h9876, 1'b1);          // R4 digits 9..6
      capture(16'h0A5F, 1'b0);          // R4 invalid nibbles
      // R5: inputs move without load
      count_bcd = 16'h4321; neg_in = 1'b0;
      step(4 * DW * 2);
      // R8 mode blanking with negative captured
      capture(16'h0555, 1'b1);
      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         step(DW * 2);
      end
      mode = 2'b00;
      // R7 blink with in-range reading: no effect
      zero_phase = 1'b1; step(DW * 4); zero_phase = 1'b0;
      capture(16'h2000, 1'b0);          // R7 just above
      for (int b = 0; b < 6; b++) begin
         zero_phase = ~zero_phase;
         step(DW * 3);
      end
      zero_phase = 1'b0;
      // back-to-back loads
      count_bcd = 16'h0042; load = 1'b1; step(1);
      count_bcd = 16'h3000; step(1);
      load = 1'b0; step(4 * DW);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule